// File: doc/BRIEF.md
# Calendar RTC Register File

A word-addressed real-time clock peripheral. It holds a packed calendar date word and a packed time-of-day word. Both advance by one second on each pulse of a one-second tick input. Four scratch registers provide plain storage. A status register records that software has loaded the date or the time, and reading that register clears the record.

Software reaches the block over a simple single-cycle bus: `bus_valid` qualifies the access and `bus_write` selects its direction. Read data is registered and appears on `bus_rdata` in the cycle after the read is accepted. Only aligned 32-bit words are decoded.

Top module: `cal_rtc_regs`

## Requirements
- R1: Register offsets are: status 0x000, date 0x010, time 0x014, scratch word i at 0x100 + 4*i for i = 0..3. Read data appears on `bus_rdata` one clock after the read is accepted.
- R2: The date word holds the day in bits [7:0], the month (1..12) in [15:8] and the year offset in [23:16]. The time word holds the second in [5:0], the minute in [13:8], the hour in [20:16] and the weekday (0 = Monday) in [31:29].
- R3: Writing the date word stores it and sets status bit 0. Writing the time word stores it and sets status bit 1. All other status bits read zero. Writes to the status register have no effect.
- R4: A status read returns the flags as they stood before the read, and both flags are zero afterwards.
- R5: The scratch words store any 32-bit value. Writing them changes no other register.
- R6: A read at an unaligned offset, an unmapped aligned offset, or an offset at or above 0x110 returns zero. A write to any of these offsets changes nothing.
- R7: After reset every register, including date and time, reads zero.
- R8: A tick adds one second. Seconds wrap at 60 into minutes, minutes wrap at 60 into hours, and hours wrap at 24 into a new day. A new day advances the weekday, with 6 wrapping to 0.
- R9: A new day advances the day of month by the length of the current month: 30 days for months 4, 6, 9 and 11, 28 days for month 2 (29 when the year offset is a multiple of 4), and 31 days otherwise. After the last day the day is 1 and the month advances. After month 12 the month is 1 and the year offset advances.
- R10: A write to the date or time word in the same cycle as a tick stores the written value, and that tick is lost for both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second pulse, one clock wide |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A wrong counter field only shows when software reads it back. A bad carry shows only at the tick that crosses the boundary, so the bench loads each calendar edge (a leap and a common February, April, December, weekday 6) and reads both words one tick later. A status flag that clears late or is set by the wrong write shows on the very next status read. The bench reads the status register right after each write and reads it again.

// File: rtl/cal_rtc_regs.sv
module cal_rtc_regs #(
  parameter int ADDR_W = 12,
  parameter int NUM_GP = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h000,
  parameter logic [ADDR_W-1:0] DATE_OFS = 12'h010,
  parameter logic [ADDR_W-1:0] TIME_OFS = 12'h014,
  parameter logic [ADDR_W-1:0] GP_BASE  = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  logic [1:0]  flags;
  logic [31:0] date_q, time_q, date_nx, time_nx, rd_val;
  logic [31:0] gp_q [NUM_GP];
  logic [NUM_GP-1:0] hit_gp;

  wire rd       = bus_valid & ~bus_write;
  wire wr       = bus_valid & bus_write;
  wire hit_ctrl = (bus_addr == CTRL_OFS);
  wire hit_date = (bus_addr == DATE_OFS);
  wire hit_time = (bus_addr == TIME_OFS);
  wire wr_dt    = wr & (hit_date | hit_time);

  for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(int'(GP_BASE) + 4 * i);
    assign hit_gp[i] = (bus_addr == OFS);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) gp_q[i] <= '0;
      else if (wr && hit_gp[i]) gp_q[i] <= bus_wdata;
  end

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
    case (mo)
      8'd2: month_len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: month_len = 8'd30;
      default: month_len = 8'd31;
    endcase
  endfunction

  wire [5:0] sec = time_q[5:0];
  wire [5:0] mnt = time_q[13:8];
  wire [4:0] hr  = time_q[20:16];
  wire [2:0] wd  = time_q[31:29];
  wire [7:0] dy  = date_q[7:0];
  wire [7:0] mo  = date_q[15:8];
  wire [7:0] yr  = date_q[23:16];

  always_comb begin
    time_nx = time_q;
    date_nx = date_q;
    if (sec < 6'd59) time_nx[5:0] = sec + 6'd1;
    else begin
      time_nx[5:0] = '0;
      if (mnt < 6'd59) time_nx[13:8] = mnt + 6'd1;
      else begin
        time_nx[13:8] = '0;
        if (hr < 5'd23) time_nx[20:16] = hr + 5'd1;
        else begin
          time_nx[20:16] = '0;
          time_nx[31:29] = (wd >= 3'd6) ? 3'd0 : wd + 3'd1;
          if (dy < month_len(mo, yr)) date_nx[7:0] = dy + 8'd1;
          else begin
            date_nx[7:0] = 8'd1;
            if (mo < 8'd12) date_nx[15:8] = mo + 8'd1;
            else begin
              date_nx[15:8]  = 8'd1;
              date_nx[23:16] = yr + 8'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      date_q <= '0;
      time_q <= '0;
    end else if (wr_dt) begin
      if (hit_date) date_q <= bus_wdata;
      if (hit_time) time_q <= bus_wdata;
    end else if (tick) begin
      date_q <= date_nx;
      time_q <= time_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else if (rd && hit_ctrl) flags <= '0;
    else if (wr && hit_date) flags[0] <= 1'b1;
    else if (wr && hit_time) flags[1] <= 1'b1;

  always_comb begin
    rd_val = '0;
    if (hit_ctrl) rd_val = {30'd0, flags};
    if (hit_date) rd_val = date_q;
    if (hit_time) rd_val = time_q;
    for (int i = 0; i < NUM_GP; i++)
      if (hit_gp[i]) rd_val = gp_q[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
endmodule

// File: rtl/cal_rtc_regs_chk.sv
module cal_rtc_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int NUM_GP = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h000,
  parameter logic [ADDR_W-1:0] DATE_OFS = 12'h010,
  parameter logic [ADDR_W-1:0] TIME_OFS = 12'h014,
  parameter logic [ADDR_W-1:0] GP_BASE  = 12'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [1:0]        flags,
  input logic [31:0]       date_q,
  input logic [31:0]       time_q
);
  localparam logic [31:0] TOP = 32'(int'(GP_BASE) + 4 * NUM_GP);

  // R4
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_addr == CTRL_OFS |=> flags == 2'b00);

  // R3
  date_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == DATE_OFS |=> flags[0] && date_q == $past(bus_wdata));

  // R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == TIME_OFS && tick |=> time_q == $past(bus_wdata));

  // R6
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && 32'(bus_addr) >= TOP |=> bus_rdata == 32'd0);

  // R8
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !bus_valid && time_q[5:0] < 6'd59 |=> time_q[5:0] == $past(time_q[5:0]) + 6'd1);
endmodule

bind cal_rtc_regs cal_rtc_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_GP(NUM_GP), .CTRL_OFS(CTRL_OFS),
  .DATE_OFS(DATE_OFS), .TIME_OFS(TIME_OFS), .GP_BASE(GP_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .flags(flags), .date_q(date_q), .time_q(time_q)
);

// File: tb/cal_rtc_regs_bench.sv
module cal_rtc_regs_bench;
  logic clk = 0, rst_n = 0, tick = 0, bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int errors = 0, checks = 0;
  bit done = 0, rd_seen = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cal_rtc_regs u_cal_rtc_regs (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [31:0] mk_t(int w, int h, int m, int s);
    return {w[2:0], 8'd0, h[4:0], 2'd0, m[5:0], 2'd0, s[5:0]};
  endfunction
  function automatic logic [31:0] mk_d(int y, int mo, int d);
    return {8'd0, y[7:0], mo[7:0], d[7:0]};
  endfunction

  task automatic wr32(logic [11:0] a, logic [31:0] d, bit with_tick = 0);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; tick = with_tick;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; tick = 0;
  endtask

  task automatic rd32(logic [11:0] a, logic [31:0] e, string tag);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic tick1();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

  always @(negedge clk) if (rd_seen && exp_q.size() > 0) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", t, bus_rdata, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    rd32(12'h000, 0, "R7 status");
    rd32(12'h010, 0, "R7 date");
    rd32(12'h014, 0, "R7 time");
    rd32(12'h10C, 0, "R7 scratch3");
    // R5 scratch storage, R1 map
    wr32(12'h100, 32'hA5A5_0001);
    wr32(12'h10C, 32'hDEAD_BEEF);
    rd32(12'h100, 32'hA5A5_0001, "R5 scratch0");
    rd32(12'h10C, 32'hDEAD_BEEF, "R5 scratch3");
    rd32(12'h104, 0, "R5 scratch1 untouched");
    rd32(12'h000, 0, "R5 no status flag");
    // R3 / R4 flags
    wr32(12'h010, mk_d(0, 2, 28));
    rd32(12'h000, 1, "R3 date flag");
    rd32(12'h000, 0, "R4 cleared");
    wr32(12'h014, mk_t(0, 23, 59, 59));
    rd32(12'h000, 2, "R3 time flag");
    rd32(12'h000, 0, "R4 cleared again");
    // R9 leap February, R8 weekday, R2 layout
    tick1();
    rd32(12'h010, mk_d(0, 2, 29), "R9 leap feb 29");
    rd32(12'h014, mk_t(1, 0, 0, 0), "R8 midnight");
    wr32(12'h014, mk_t(6, 23, 59, 59));
    tick1();
    rd32(12'h010, mk_d(0, 3, 1), "R9 leap feb end");
    rd32(12'h014, mk_t(0, 0, 0, 0), "R8 weekday wrap");
    wr32(12'h010, mk_d(1, 2, 28));
    wr32(12'h014, mk_t(2, 23, 59, 59));
    tick1();
    rd32(12'h010, mk_d(1, 3, 1), "R9 common feb");
    rd32(12'h014, mk_t(3, 0, 0, 0), "R8 new day");
    wr32(12'h010, mk_d(5, 12, 31));
    wr32(12'h014, mk_t(4, 23, 59, 59));
    tick1();
    rd32(12'h010, mk_d(6, 1, 1), "R9 year end");
    wr32(12'h010, mk_d(5, 4, 30));
    wr32(12'h014, mk_t(5, 23, 59, 59));
    tick1();
    rd32(12'h010, mk_d(5, 5, 1), "R9 april end");
    rd32(12'h014, mk_t(6, 0, 0, 0), "R8 weekday 6");
    // R8 plain carries
    wr32(12'h014, mk_t(0, 10, 10, 5));
    tick1();
    rd32(12'h014, mk_t(0, 10, 10, 6), "R8 second step");
    wr32(12'h014, mk_t(0, 10, 10, 59));
    tick1();
    rd32(12'h014, mk_t(0, 10, 11, 0), "R8 minute carry");
    wr32(12'h014, mk_t(0, 10, 59, 59));
    tick1();
    rd32(12'h014, mk_t(0, 11, 0, 0), "R8 hour carry");
    rd32(12'h000, 3, "R3 both flags");
    // R10 write beats tick
    wr32(12'h014, mk_t(3, 7, 8, 9), 1);
    rd32(12'h014, mk_t(3, 7, 8, 9), "R10 time written");
    rd32(12'h010, mk_d(5, 5, 1), "R10 date untouched");
    wr32(12'h010, mk_d(7, 7, 7), 1);
    rd32(12'h010, mk_d(7, 7, 7), "R10 date written");
    rd32(12'h014, mk_t(3, 7, 8, 9), "R10 time untouched");
    rd32(12'h000, 3, "R4 flags before clear");
    // R3 status write ignored
    wr32(12'h000, 32'hFFFF_FFFF);
    rd32(12'h000, 0, "R3 status write ignored");
    // R6 unmapped, out of range, unaligned
    wr32(12'h020, 32'h123);
    rd32(12'h020, 0, "R6 unmapped");
    wr32(12'h110, 32'h456);
    rd32(12'h110, 0, "R6 window top");
    rd32(12'h200, 0, "R6 out of range");
    wr32(12'h102, 32'hFFFF_FFFF);
    rd32(12'h102, 0, "R6 unaligned read");
    rd32(12'h100, 32'hA5A5_0001, "R6 unaligned write ignored");
    wr32(12'h012, 32'h1);
    rd32(12'h010, mk_d(7, 7, 7), "R6 date unchanged");
    rd32(12'h000, 0, "R6 no flag");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule